// File: doc/BRIEF.md
# Interrupt Merge and Intrusion Pulse Controller

This block gathers the interrupt causes of a hardware-monitoring subsystem and presents them on two host-facing lines: a system-management interrupt line (active low, open drain) and a shared host interrupt line that works either as a non-maskable interrupt (driven high) or as an ordinary interrupt request (driven low). The causes are a vector of limit-violation events from the comparator stage, an active-low board-temperature alarm, an active-low chained interrupt from a downstream device, and a chassis-intrusion detector.

Every cause except intrusion sets a bit in a sticky status word that is cleared when software reads it. Intrusion has its own latch, which ignores reads and is emptied only by a self-timed clear pulse that pulls the intrusion line low. A second self-timed pulse drives an active-low master reset. Both pulses last a fixed time derived from the clock frequency, and a new trigger during a pulse restarts the full width. A write port holds a configuration register and one pair of mask registers per output line.

Top module: `irq_intrusion_ctrl`

## Requirements
- R1: After reset `smi_n_o` and `master_rst_n_o` are 1, `hostint_drive_o`, `hostint_level_o` and `intr_clr_o` are 0, both read selections return 0, and every mask bit is 1 (masked).
- R2: Configuration register (address 0): bit 1 enables the SMI line, bit 2 enables the host line, bit 5 selects the host mode. With bit 5 set, `hostint_level_o` is 1 (NMI, drives high). With bit 5 clear it is 0 (IRQ, drives low).
- R3: Status word (read select 0): bits 0 to NUM_LIMIT-1 follow `limit_evt_i`, bit NUM_LIMIT (bit 6 by default) is the chained input `chain_n_i` low, and bit NUM_LIMIT+1 is `board_temp_n_i` low. A bit becomes set at any clock edge where its source is active and stays set.
- R4: A read of status (`rd_en_i` with `rd_sel_i`=0) clears the word at that edge. A source active at that same edge leaves its bit set.
- R5: `smi_n_o` is 0 exactly when SMI is enabled and either a status bit is 1 with its SMI mask bit (address 1, 1 = masked) at 0, or the intrusion latch is set with SMI mask-2 (address 2) bit 0 at 0.
- R6: `hostint_drive_o` is 1 exactly when the host line is enabled and either a status bit is 1 with its host mask bit (address 3) at 0, or the intrusion latch is set with host mask-2 (address 4) bit 0 at 0.
- R7: The intrusion latch (read select 1, bit 0) is set whenever `intrusion_i` is high, stays set after the input falls, and is not cleared by reads.
- R8: A write to address 4 with bit 7 set drives `intr_clr_o` high from the following cycle for PULSE_CYCLES cycles. The latch is cleared at the write edge and stays clear while the pulse lasts, whatever the value of `intrusion_i`.
- R9: A write to address 2 with bit 7 set drives `master_rst_n_o` low from the following cycle for PULSE_CYCLES cycles.
- R10: A new trigger while a pulse runs restarts it, so the line stays active for PULSE_CYCLES cycles after the last trigger.
- R11: Writes to address 2 or 4 with bit 7 clear start no pulse. Bit 7 is not stored. Bit 0 of those writes sets the intrusion mask.
- R12: PULSE_CYCLES equals CLK_HZ / 1000 * PULSE_MS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Status read strobe (clears status when select is 0) |
| rd_sel_i | input | 1 | Read select: 0 status word, 1 intrusion latch |
| rd_data_o | output | 8 | Read data |
| limit_evt_i | input | NUM_LIMIT | Limit-violation events, active high |
| chain_n_i | input | 1 | Chained interrupt input, active low |
| board_temp_n_i | input | 1 | Board temperature alarm, active low |
| intrusion_i | input | 1 | Chassis intrusion detector, active high |
| smi_n_o | output | 1 | System-management interrupt, active low |
| hostint_drive_o | output | 1 | Host interrupt line is driven |
| hostint_level_o | output | 1 | Level driven on the host line (1 NMI, 0 IRQ) |
| intr_clr_o | output | 1 | Pulls the intrusion line low while 1 |
| master_rst_n_o | output | 1 | Master reset pulse, active low |

## Verification
A source can assert in the same cycle that software reads and clears the status word, and the set has to win over the clear. The bench holds the chained input low across a status read, checks that the read returns the bit, and checks that the bit is still set on the next read. A source that was released before the read is checked to be gone. A second collision, the clear pulse against a still-high intrusion input, is judged by watching the latch stay 0 for every cycle of the pulse and then set one cycle after the pulse ends.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int REG_W = 8;

    // register addresses on the write port
    localparam logic [2:0] ADDR_CFG        = 3'd0;
    localparam logic [2:0] ADDR_SMI_MASK   = 3'd1;
    localparam logic [2:0] ADDR_SMI_MASK2  = 3'd2;
    localparam logic [2:0] ADDR_HOST_MASK  = 3'd3;
    localparam logic [2:0] ADDR_HOST_MASK2 = 3'd4;

    // configuration bit positions
    localparam int CFG_SMI_EN_BIT  = 1;
    localparam int CFG_HOST_EN_BIT = 2;
    localparam int CFG_NMI_BIT     = 5;

    // second-mask bit positions
    localparam int M2_INTR_BIT  = 0;
    localparam int M2_PULSE_BIT = 7;

    typedef struct packed {
        logic smi_en;
        logic host_en;
        logic nmi_mode;
    } cfg_t;

endpackage

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int W = 8
) (
    input  logic         en_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    input  logic         intr_i,
    input  logic         intr_mask_i,
    output logic         assert_o
);
    logic any_src;

    always_comb begin
        any_src  = |(status_i & ~mask_i);
        assert_o = en_i & (any_src | (intr_i & ~intr_mask_i));
    end

endmodule

// File: rtl/irq_intrusion_ctrl.sv
module irq_intrusion_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LIMIT = 6,
    parameter int CLK_HZ    = 1_000_000,
    parameter int PULSE_MS  = 20
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic [2:0]           wr_addr_i,
    input  logic [REG_W-1:0]     wr_data_i,
    input  logic                 rd_en_i,
    input  logic                 rd_sel_i,
    output logic [REG_W-1:0]     rd_data_o,
    input  logic [NUM_LIMIT-1:0] limit_evt_i,
    input  logic                 chain_n_i,
    input  logic                 board_temp_n_i,
    input  logic                 intrusion_i,
    output logic                 smi_n_o,
    output logic                 hostint_drive_o,
    output logic                 hostint_level_o,
    output logic                 intr_clr_o,
    output logic                 master_rst_n_o
);
    localparam int STAT_W       = NUM_LIMIT + 2;
    localparam int CHAIN_BIT    = NUM_LIMIT;
    localparam int PULSE_CYCLES = CLK_HZ / 1000 * PULSE_MS;
    localparam int NUM_OUT      = 2;

    typedef struct packed {
        cfg_t              cfg;
        logic [STAT_W-1:0] smi_mask;
        logic              smi_intr_mask;
        logic [STAT_W-1:0] host_mask;
        logic              host_intr_mask;
        logic [STAT_W-1:0] status;
        logic              intr_latch;
    } state_t;

    state_t s_d, s_q;

    logic              clr_start, rst_start;
    logic              clr_active, rst_active;
    logic [STAT_W-1:0] src_evt;
    logic              rd_clear;

    logic [STAT_W-1:0] mask_arr  [NUM_OUT];
    logic              imask_arr [NUM_OUT];
    logic              en_arr    [NUM_OUT];
    logic              out_arr   [NUM_OUT];

    // next-state computation
    always_comb begin
        s_d       = s_q;
        clr_start = 1'b0;
        rst_start = 1'b0;
        src_evt   = {~board_temp_n_i, ~chain_n_i, limit_evt_i};
        rd_clear  = rd_en_i & ~rd_sel_i;

        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_CFG: begin
                    s_d.cfg.smi_en   = wr_data_i[CFG_SMI_EN_BIT];
                    s_d.cfg.host_en  = wr_data_i[CFG_HOST_EN_BIT];
                    s_d.cfg.nmi_mode = wr_data_i[CFG_NMI_BIT];
                end
                ADDR_SMI_MASK:  s_d.smi_mask  = wr_data_i[STAT_W-1:0];
                ADDR_HOST_MASK: s_d.host_mask = wr_data_i[STAT_W-1:0];
                ADDR_SMI_MASK2: begin
                    s_d.smi_intr_mask = wr_data_i[M2_INTR_BIT];
                    rst_start         = wr_data_i[M2_PULSE_BIT];
                end
                ADDR_HOST_MASK2: begin
                    s_d.host_intr_mask = wr_data_i[M2_INTR_BIT];
                    clr_start          = wr_data_i[M2_PULSE_BIT];
                end
                default: ;
            endcase
        end

        // sticky status, clear on read, set wins over clear
        s_d.status = (rd_clear ? '0 : s_q.status) | src_evt;

        // intrusion latch: held clear while the clear pulse runs
        if (clr_start || clr_active) begin
            s_d.intr_latch = 1'b0;
        end else begin
            s_d.intr_latch = s_q.intr_latch | intrusion_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.cfg            <= '0;
            s_q.smi_mask       <= '1;
            s_q.smi_intr_mask  <= 1'b1;
            s_q.host_mask      <= '1;
            s_q.host_intr_mask <= 1'b1;
            s_q.status         <= '0;
            s_q.intr_latch     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // pulse generators
    irq_pulse_timer #(.CYCLES(PULSE_CYCLES)) i_clr_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (clr_start),
        .active_o (clr_active)
    );

    irq_pulse_timer #(.CYCLES(PULSE_CYCLES)) i_rst_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (rst_start),
        .active_o (rst_active)
    );

    // output merging: index 0 SMI, index 1 host line
    always_comb begin
        mask_arr[0]  = s_q.smi_mask;
        imask_arr[0] = s_q.smi_intr_mask;
        en_arr[0]    = s_q.cfg.smi_en;
        mask_arr[1]  = s_q.host_mask;
        imask_arr[1] = s_q.host_intr_mask;
        en_arr[1]    = s_q.cfg.host_en;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_merge
        irq_merge #(.W(STAT_W)) i_merge (
            .en_i        (en_arr[g]),
            .status_i    (s_q.status),
            .mask_i      (mask_arr[g]),
            .intr_i      (s_q.intr_latch),
            .intr_mask_i (imask_arr[g]),
            .assert_o    (out_arr[g])
        );
    end

    always_comb begin
        rd_data_o       = rd_sel_i ? REG_W'(s_q.intr_latch) : REG_W'(s_q.status);
        smi_n_o         = ~out_arr[0];
        hostint_drive_o = out_arr[1];
        hostint_level_o = s_q.cfg.nmi_mode;
        intr_clr_o      = clr_active;
        master_rst_n_o  = ~rst_active;
    end

endmodule

// File: rtl/irq_intrusion_ctrl_checker.sv
module irq_intrusion_ctrl_checker #(
    parameter int PULSE_CYCLES = 20,
    parameter int STAT_W       = 8,
    parameter int CHAIN_BIT    = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              rd_sel_i,
    input logic              chain_n_i,
    input logic              smi_n_o,
    input logic              hostint_drive_o,
    input logic              intr_clr_o,
    input logic              master_rst_n_o,
    input logic              smi_en,
    input logic              host_en,
    input logic [STAT_W-1:0] smi_mask,
    input logic [STAT_W-1:0] status,
    input logic              intr_latch
);
    logic [31:0] clr_len, rst_len;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            clr_len <= '0;
            rst_len <= '0;
        end else begin
            clr_len <= intr_clr_o ? ((clr_len == 32'hFFFF_FFFF) ? clr_len : clr_len + 1) : '0;
            rst_len <= !master_rst_n_o ? ((rst_len == 32'hFFFF_FFFF) ? rst_len : rst_len + 1) : '0;
        end
    end

    assert_smi_needs_enable_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !smi_n_o |-> smi_en);

    assert_host_needs_enable_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        hostint_drive_o |-> host_en);

    assert_chain_reaches_smi_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!chain_n_i && smi_en && !smi_mask[CHAIN_BIT] && !wr_en_i) |=> !smi_n_o);

    assert_set_beats_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && !rd_sel_i && !chain_n_i) |=> status[CHAIN_BIT]);

    assert_latch_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(intr_latch) && !intr_clr_o) |-> intr_latch);

    assert_latch_clear_in_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        intr_clr_o |-> !intr_latch);

    assert_clr_min_width_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(intr_clr_o) |-> (clr_len >= PULSE_CYCLES));

    assert_rst_min_width_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(master_rst_n_o) |-> (rst_len >= PULSE_CYCLES));

endmodule

bind irq_intrusion_ctrl irq_intrusion_ctrl_checker #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .STAT_W       (STAT_W),
    .CHAIN_BIT    (CHAIN_BIT)
) i_checker (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .wr_en_i         (wr_en_i),
    .rd_en_i         (rd_en_i),
    .rd_sel_i        (rd_sel_i),
    .chain_n_i       (chain_n_i),
    .smi_n_o         (smi_n_o),
    .hostint_drive_o (hostint_drive_o),
    .intr_clr_o      (intr_clr_o),
    .master_rst_n_o  (master_rst_n_o),
    .smi_en          (s_q.cfg.smi_en),
    .host_en         (s_q.cfg.host_en),
    .smi_mask        (s_q.smi_mask),
    .status          (s_q.status),
    .intr_latch      (s_q.intr_latch)
);

// File: tb/test_irq_intrusion_ctrl.sv
module test_irq_intrusion_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NUM_LIMIT  = 6;
    localparam int  CLK_HZ     = 1000;
    localparam int  PULSE_MS   = 20;
    localparam int  EXP_PULSE  = 20;   // 1000 / 1000 * 20

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_en = 1'b0;
    logic [2:0]           wr_addr = '0;
    logic [7:0]           wr_data = '0;
    logic                 rd_en = 1'b0;
    logic                 rd_sel = 1'b0;
    logic [7:0]           rd_data;
    logic [NUM_LIMIT-1:0] limit_evt = '0;
    logic                 chain_n = 1'b1;
    logic                 temp_n = 1'b1;
    logic                 intrusion = 1'b0;
    logic                 smi_n, host_drive, host_level, intr_clr, mrst_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_intrusion_ctrl #(
        .NUM_LIMIT (NUM_LIMIT),
        .CLK_HZ    (CLK_HZ),
        .PULSE_MS  (PULSE_MS)
    ) i_irq_intrusion_ctrl (
        .clk_i           (clk),
        .rst_i           (rst),
        .wr_en_i         (wr_en),
        .wr_addr_i       (wr_addr),
        .wr_data_i       (wr_data),
        .rd_en_i         (rd_en),
        .rd_sel_i        (rd_sel),
        .rd_data_o       (rd_data),
        .limit_evt_i     (limit_evt),
        .chain_n_i       (chain_n),
        .board_temp_n_i  (temp_n),
        .intrusion_i     (intrusion),
        .smi_n_o         (smi_n),
        .hostint_drive_o (host_drive),
        .hostint_level_o (host_level),
        .intr_clr_o      (intr_clr),
        .master_rst_n_o  (mrst_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] v);
        rd_en  = 1'b1;
        rd_sel = sel;
        #1 v = rd_data;
        tick(1);
        rd_en  = 1'b0;
        rd_sel = 1'b0;
    endtask

    // counts cycles for which the probed line is active, starting now
    task automatic measure_clr(output int len);
        len = 0;
        while (intr_clr && len < 1000) begin
            len++;
            tick(1);
        end
    endtask

    task automatic measure_rst(output int len);
        len = 0;
        while (!mrst_n && len < 1000) begin
            len++;
            tick(1);
        end
    endtask

    task automatic test_reset();
        logic [7:0] v;
        check("R1 smi_n", smi_n, 1'b1);
        check("R1 host drive", host_drive, 1'b0);
        check("R1 host level IRQ", host_level, 1'b0);
        check("R1 clear pulse", intr_clr, 1'b0);
        check("R1 master reset", mrst_n, 1'b1);
        read_reg(1'b0, v);
        check("R1 status", v, 8'h00);
        read_reg(1'b1, v);
        check("R1 latch", v, 8'h00);
        // masks reset to 1: enable both lines, raise a source, nothing asserts
        write_reg(3'd0, 8'h06);
        limit_evt = 6'b000001;
        tick(1);
        limit_evt = '0;
        check("R1 smi masked after reset", smi_n, 1'b1);
        check("R1 host masked after reset", host_drive, 1'b0);
        read_reg(1'b0, v);
        write_reg(3'd0, 8'h00);
    endtask

    task automatic test_status_map();
        logic [7:0] v;
        limit_evt = 6'b001000;
        tick(1);
        limit_evt = '0;
        chain_n = 1'b0;
        tick(1);
        chain_n = 1'b1;
        temp_n = 1'b0;
        tick(1);
        temp_n = 1'b1;
        tick(2);
        read_reg(1'b0, v);
        check("R3 status bit map", v, 8'hC8);
        read_reg(1'b0, v);
        check("R4 cleared on read", v, 8'h00);
    endtask

    task automatic test_set_vs_read();
        logic [7:0] v;
        limit_evt = 6'b000010;
        tick(1);
        limit_evt = '0;
        chain_n = 1'b0;
        tick(1);
        read_reg(1'b0, v);           // chained source active at the read edge
        check("R4 read returns both", v, 8'h42);
        chain_n = 1'b1;
        read_reg(1'b0, v);
        check("R4 set wins over clear", v, 8'h40);
        read_reg(1'b0, v);
        check("R4 finally empty", v, 8'h00);
    endtask

    task automatic test_smi_mask();
        logic [7:0] v;
        write_reg(3'd0, 8'h02);      // SMI enable
        chain_n = 1'b0;
        tick(2);
        check("R5 chained masked", smi_n, 1'b1);
        write_reg(3'd1, 8'hBF);      // unmask bit 6
        check("R5 chained unmasked", smi_n, 1'b0);
        check("R6 host idle when disabled", host_drive, 1'b0);
        chain_n = 1'b1;
        write_reg(3'd0, 8'h00);
        check("R5 smi disabled", smi_n, 1'b1);
        write_reg(3'd0, 8'h02);
        check("R5 pending reasserts", smi_n, 1'b0);
        read_reg(1'b0, v);
        check("R5 released after read", smi_n, 1'b1);
        write_reg(3'd1, 8'hFF);
        write_reg(3'd0, 8'h00);
    endtask

    task automatic test_host_mode();
        logic [7:0] v;
        write_reg(3'd0, 8'h24);      // host enable, NMI mode
        write_reg(3'd3, 8'h7F);      // unmask board temperature
        check("R2 NMI level", host_level, 1'b1);
        check("R6 idle", host_drive, 1'b0);
        temp_n = 1'b0;
        tick(1);
        temp_n = 1'b1;
        check("R6 drive on temp", host_drive, 1'b1);
        write_reg(3'd0, 8'h04);      // IRQ mode
        check("R2 IRQ level", host_level, 1'b0);
        check("R6 still driven", host_drive, 1'b1);
        read_reg(1'b0, v);
        check("R6 released", host_drive, 1'b0);
        write_reg(3'd3, 8'hFF);
        write_reg(3'd0, 8'h00);
    endtask

    task automatic test_intrusion_latch();
        logic [7:0] v;
        intrusion = 1'b1;
        tick(1);
        intrusion = 1'b0;
        tick(2);
        read_reg(1'b1, v);
        check("R7 latch set", v, 8'h01);
        read_reg(1'b1, v);
        check("R7 not cleared by read", v, 8'h01);
        read_reg(1'b0, v);
        check("R7 not in status word", v, 8'h00);
        write_reg(3'd0, 8'h02);
        write_reg(3'd2, 8'h00);      // unmask intrusion on SMI, no pulse
        check("R5 intrusion reaches smi", smi_n, 1'b0);
        check("R11 no reset pulse", mrst_n, 1'b1);
    endtask

    task automatic test_clear_pulse();
        int len;
        int bad;
        logic [7:0] v;
        intrusion = 1'b1;            // input still high across the clear
        write_reg(3'd4, 8'h81);
        check("R5 smi drops with latch", smi_n, 1'b1);
        rd_sel = 1'b1;
        len = 0;
        bad = 0;
        while (intr_clr && len < 1000) begin
            #1 if (rd_data[0] !== 1'b0) bad++;
            len++;
            tick(1);
        end
        rd_sel = 1'b0;
        check("R8 clear pulse width", len, EXP_PULSE);
        check("R12 width from parameters", len, 32'(CLK_HZ / 1000 * PULSE_MS));
        check("R8 latch held clear", bad, 0);
        tick(1);
        read_reg(1'b1, v);
        check("R8 relatch after pulse", v, 8'h01);
        intrusion = 1'b0;
        write_reg(3'd4, 8'h01);      // bit 7 clear
        check("R11 no clear pulse", intr_clr, 1'b0);
        read_reg(1'b1, v);
        check("R11 latch kept", v, 8'h01);
        write_reg(3'd4, 8'h80);
        measure_clr(len);
        write_reg(3'd2, 8'h01);
        write_reg(3'd0, 8'h00);
    endtask

    task automatic test_reset_pulse();
        int len;
        write_reg(3'd2, 8'h81);
        check("R9 reset asserted", mrst_n, 1'b0);
        measure_rst(len);
        check("R9 reset pulse width", len, EXP_PULSE);
        tick(3);
        check("R9 reset released", mrst_n, 1'b1);
    endtask

    task automatic test_retrigger();
        int len;
        write_reg(3'd2, 8'h81);
        tick(7);                     // 8 cycles active so far
        write_reg(3'd2, 8'h81);
        measure_rst(len);
        check("R10 reset retrigger", len, EXP_PULSE);
        write_reg(3'd4, 8'h80);
        tick(11);
        write_reg(3'd4, 8'h80);
        measure_clr(len);
        check("R10 clear retrigger", len, EXP_PULSE);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        test_reset();
        test_status_map();
        test_set_vs_read();
        test_smi_mask();
        test_host_mode();
        test_intrusion_latch();
        test_clear_pulse();
        test_reset_pulse();
        test_retrigger();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule